// File: doc/BRIEF.md
# SMT Commit Thread Selector

In a core that runs several hardware threads, each thread keeps its own reorder-buffer partition. Only one thread may retire its head in a given commit slot. This block picks that thread. For each thread it reads a commit state code, a buffer-empty flag, a head-ready flag and the head's sequence number. It returns a grant valid flag and the index of the granted thread. The retirement logic around it pulses an advance input when it uses a grant. That pulse is the only thing that changes the stored round-robin order.

A two-bit policy input picks how the choice is made. In the age policy, the qualified thread whose head carries the smallest sequence number wins. The greedy policy uses the same age choice, so the caller can evaluate it again for each extra slot in a cycle. The rotate policy scans a stored priority list from front to back. When a rotate grant is consumed, the granted thread goes to the back of the list. A build with one thread skips the readiness test entirely.

Top module: `csel_commit_sel`

## Requirements
- R1: A thread is eligible only when its state code is 0 (idle), 1 (running) or 4 (waiting on a fetch trap). Codes 2 (squashing), 3 (waiting on a trap) and 5 to 7 are ineligible. With more than one thread, a thread qualifies when it is eligible, its empty flag is 0 and its ready flag is 1. Only qualified threads are ever granted.
- R2: When no thread qualifies under the active policy, `grant_vld_o` is 0 and `grant_tid_o` is 0.
- R3: Policy 2 (age) grants the qualified thread with the smallest unsigned head sequence number. On equal numbers, the lower thread index wins.
- R4: Policy 0 (greedy) gives the same grant as policy 2 for every input pattern.
- R5: Policy 1 (rotate) grants the first qualified thread found when the stored list is read from front to back.
- R6: After reset, the stored list holds threads 0, 1, ..., N-1 from front to back.
- R7: On a clock edge where `advance_i` is 1, the policy is 1 and a grant is valid, the granted thread moves to the tail of the list. The other threads keep their relative order.
- R8: The list does not change on any other edge: when advance is low, when there is no valid grant, or when the policy is not 1.
- R9: With more than one thread, policy 3 never grants.
- R10: With one thread, the block grants thread 0 exactly when its state is eligible (R1). It ignores the empty flag, the ready flag and the policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | 0 greedy, 1 rotate, 2 age, 3 off |
| thr_state_i | input | 3*NUM_THR | Commit state code per thread; thread t is at bits [3t+2:3t] |
| thr_empty_i | input | NUM_THR | Per-thread buffer-empty flag |
| thr_ready_i | input | NUM_THR | Per-thread head-ready flag |
| thr_seq_i | input | SEQ_W*NUM_THR | Head sequence number per thread; thread t is at bits [SEQ_W*t +: SEQ_W] |
| advance_i | input | 1 | Grant consumed this cycle |
| grant_vld_o | output | 1 | A thread is granted |
| grant_tid_o | output | TID_W | Granted thread index |

## Verification
The assertions assume that sequence numbers from different threads can be compared directly as unsigned values. They also assume that `advance_i` means something only when it comes together with a valid rotate grant. The bench holds every input steady across each clock edge. It uses four threads and 4-bit sequence numbers, so ties show up often. It drives every state code, including the out-of-range ones, and pulses advance under every policy, with and without a grant. A second instance with a single thread is swept over all state, empty and ready combinations.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    TS_IDLE       = 3'd0,
    TS_RUN        = 3'd1,
    TS_SQUASH     = 3'd2,
    TS_TRAP_WAIT  = 3'd3,
    TS_FETCH_TRAP = 3'd4
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_GREEDY = 2'd0,
    POL_ROTATE = 2'd1,
    POL_AGE    = 2'd2,
    POL_OFF    = 2'd3
  } pol_e;

  // A commit state that allows this thread to be picked.
  function automatic logic state_ok(input logic [STATE_W-1:0] s);
    return (s == TS_IDLE) || (s == TS_RUN) || (s == TS_FETCH_TRAP);
  endfunction

  // True when sequence number a is strictly older than b.
  function automatic logic seq_older(input logic [63:0] a, input logic [63:0] b);
    return a < b;
  endfunction

endpackage

// File: rtl/csel_qualify.sv
module csel_qualify
  import csel_pkg::*;
#(
  parameter int NUM_THR = 4,
  parameter bit SINGLE  = 1'b0
) (
  input  logic [NUM_THR*STATE_W-1:0] state_i,
  input  logic [NUM_THR-1:0]         empty_i,
  input  logic [NUM_THR-1:0]         ready_i,
  output logic [NUM_THR-1:0]         elig_o,
  output logic [NUM_THR-1:0]         qual_o
);

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign elig_o[t] = state_ok(state_i[t*STATE_W +: STATE_W]);
    if (SINGLE) begin : g_single
      assign qual_o[t] = elig_o[t];
    end else begin : g_multi
      assign qual_o[t] = elig_o[t] & ~empty_i[t] & ready_i[t];
    end
  end

endmodule

// File: rtl/csel_age_pick.sv
module csel_age_pick
  import csel_pkg::*;
#(
  parameter int NUM_THR = 4,
  parameter int SEQ_W   = 16,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic [NUM_THR-1:0]       qual_i,
  input  logic [NUM_THR*SEQ_W-1:0] seq_i,
  output logic                     vld_o,
  output logic [TID_W-1:0]         tid_o
);

  logic [SEQ_W-1:0] best;

  always_comb begin
    vld_o = 1'b0;
    tid_o = '0;
    best  = '0;
    for (int t = 0; t < NUM_THR; t++) begin
      // strict comparison keeps the lower index on a tie
      if (qual_i[t] &&
          (!vld_o || seq_older(64'(seq_i[t*SEQ_W +: SEQ_W]), 64'(best)))) begin
        vld_o = 1'b1;
        tid_o = TID_W'(t);
        best  = seq_i[t*SEQ_W +: SEQ_W];
      end
    end
  end

endmodule

// File: rtl/csel_rr_list.sv
module csel_rr_list #(
  parameter int NUM_THR = 4,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_THR-1:0]       qual_i,
  input  logic                     upd_i,
  output logic                     vld_o,
  output logic [TID_W-1:0]         tid_o,
  output logic [NUM_THR*TID_W-1:0] list_o
);

  logic [TID_W-1:0] order_q [NUM_THR];
  logic [TID_W-1:0] order_d [NUM_THR];
  logic [TID_W-1:0] pos;

  // front-to-back scan for the first qualified entry
  always_comb begin
    vld_o = 1'b0;
    tid_o = '0;
    pos   = '0;
    for (int p = 0; p < NUM_THR; p++) begin
      if (!vld_o && qual_i[order_q[p]]) begin
        vld_o = 1'b1;
        tid_o = order_q[p];
        pos   = TID_W'(p);
      end
    end
  end

  // remove the picked slot, close the gap, append it at the tail
  always_comb begin
    for (int p = 0; p < NUM_THR - 1; p++) begin
      order_d[p] = (TID_W'(p) >= pos) ? order_q[p+1] : order_q[p];
    end
    order_d[NUM_THR-1] = order_q[pos];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_THR; p++) order_q[p] <= TID_W'(p);
    end else if (upd_i) begin
      for (int p = 0; p < NUM_THR; p++) order_q[p] <= order_d[p];
    end
  end

  for (genvar p = 0; p < NUM_THR; p++) begin : g_flat
    assign list_o[p*TID_W +: TID_W] = order_q[p];
  end

endmodule

// File: rtl/csel_commit_sel.sv
module csel_commit_sel
  import csel_pkg::*;
#(
  parameter int NUM_THR = 4,
  parameter int SEQ_W   = 16,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 policy_i,
  input  logic [NUM_THR*STATE_W-1:0] thr_state_i,
  input  logic [NUM_THR-1:0]         thr_empty_i,
  input  logic [NUM_THR-1:0]         thr_ready_i,
  input  logic [NUM_THR*SEQ_W-1:0]   thr_seq_i,
  input  logic                       advance_i,
  output logic                       grant_vld_o,
  output logic [TID_W-1:0]           grant_tid_o
);

  // named internal events, brought out for the checker
  logic [NUM_THR-1:0]       elig_mask;
  logic [NUM_THR-1:0]       qual_mask;
  logic [NUM_THR*TID_W-1:0] rr_list_flat;
  logic                     rr_upd;

  csel_qualify #(.NUM_THR(NUM_THR), .SINGLE(NUM_THR == 1)) u_qual (
    .state_i (thr_state_i),
    .empty_i (thr_empty_i),
    .ready_i (thr_ready_i),
    .elig_o  (elig_mask),
    .qual_o  (qual_mask)
  );

  if (NUM_THR == 1) begin : g_one
    assign grant_vld_o  = qual_mask[0];
    assign grant_tid_o  = '0;
    assign rr_list_flat = '0;
    assign rr_upd       = 1'b0;
  end else begin : g_many
    logic             age_vld, rr_vld;
    logic [TID_W-1:0] age_tid, rr_tid;

    csel_age_pick #(.NUM_THR(NUM_THR), .SEQ_W(SEQ_W)) u_age (
      .qual_i (qual_mask),
      .seq_i  (thr_seq_i),
      .vld_o  (age_vld),
      .tid_o  (age_tid)
    );

    assign rr_upd = advance_i && rr_vld && (pol_e'(policy_i) == POL_ROTATE);

    csel_rr_list #(.NUM_THR(NUM_THR)) u_rr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .qual_i (qual_mask),
      .upd_i  (rr_upd),
      .vld_o  (rr_vld),
      .tid_o  (rr_tid),
      .list_o (rr_list_flat)
    );

    always_comb begin
      unique case (pol_e'(policy_i))
        POL_GREEDY, POL_AGE: begin
          grant_vld_o = age_vld;
          grant_tid_o = age_tid;
        end
        POL_ROTATE: begin
          grant_vld_o = rr_vld;
          grant_tid_o = rr_tid;
        end
        default: begin
          grant_vld_o = 1'b0;
          grant_tid_o = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/csel_commit_sel_chk.sv
module csel_commit_sel_chk
  import csel_pkg::*;
#(
  parameter int NUM_THR = 4,
  parameter int SEQ_W   = 16,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [1:0]                 policy_i,
  input logic [NUM_THR*STATE_W-1:0] thr_state_i,
  input logic [NUM_THR-1:0]         thr_empty_i,
  input logic [NUM_THR-1:0]         thr_ready_i,
  input logic [NUM_THR*SEQ_W-1:0]   thr_seq_i,
  input logic                       advance_i,
  input logic                       grant_vld_o,
  input logic [TID_W-1:0]           grant_tid_o,
  input logic [NUM_THR*TID_W-1:0]   rr_list_flat
);

  logic [NUM_THR-1:0] q_mask;
  logic [NUM_THR-1:0] occ;
  logic               age_ok;
  logic               upd;
  logic [SEQ_W-1:0]   gseq;

  always_comb begin
    for (int t = 0; t < NUM_THR; t++) begin
      q_mask[t] = state_ok(thr_state_i[t*STATE_W +: STATE_W]) &&
                  !thr_empty_i[t] && thr_ready_i[t];
    end
  end

  always_comb begin
    occ = '0;
    for (int p = 0; p < NUM_THR; p++) occ[rr_list_flat[p*TID_W +: TID_W]] = 1'b1;
  end

  always_comb begin
    gseq   = thr_seq_i[grant_tid_o*SEQ_W +: SEQ_W];
    age_ok = 1'b1;
    for (int t = 0; t < NUM_THR; t++) begin
      if (q_mask[t]) begin
        if (thr_seq_i[t*SEQ_W +: SEQ_W] < gseq) age_ok = 1'b0;
        if (thr_seq_i[t*SEQ_W +: SEQ_W] == gseq && TID_W'(t) < grant_tid_o) age_ok = 1'b0;
      end
    end
  end

  assign upd = advance_i && grant_vld_o && (policy_i == 2'd1) && (NUM_THR > 1);

  p_idle_tid_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_vld_o |-> grant_tid_o == '0);

  p_list_perm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(occ) == NUM_THR);

  p_tail_move_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> rr_list_flat[(NUM_THR-1)*TID_W +: TID_W] == $past(grant_tid_o));

  p_list_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(rr_list_flat));

  if (NUM_THR > 1) begin : g_multi
    p_grant_qualified_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_vld_o |-> q_mask[grant_tid_o]);

    p_none_no_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_mask == '0) |-> !grant_vld_o);

    p_oldest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_vld_o && (policy_i == 2'd2 || policy_i == 2'd0)) |-> age_ok);

    p_age_any_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((policy_i == 2'd0 || policy_i == 2'd2) && q_mask != '0) |-> grant_vld_o);

    p_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i == 2'd3) |-> !grant_vld_o);
  end else begin : g_single
    p_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_vld_o == state_ok(thr_state_i[STATE_W-1:0]));
  end

endmodule

bind csel_commit_sel csel_commit_sel_chk #(.NUM_THR(NUM_THR), .SEQ_W(SEQ_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .policy_i     (policy_i),
  .thr_state_i  (thr_state_i),
  .thr_empty_i  (thr_empty_i),
  .thr_ready_i  (thr_ready_i),
  .thr_seq_i    (thr_seq_i),
  .advance_i    (advance_i),
  .grant_vld_o  (grant_vld_o),
  .grant_tid_o  (grant_tid_o),
  .rr_list_flat (rr_list_flat)
);

// File: tb/csel_commit_sel_bench.sv
module csel_commit_sel_bench;

  localparam int N  = 4;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    pol = 2'd0;
  logic [N*3-1:0] st = '0;
  logic [N-1:0]  emp = '0;
  logic [N-1:0]  rdy = '0;
  logic [N*SW-1:0] seq = '0;
  logic          adv = 1'b0;
  logic          g_vld;
  logic [1:0]    g_tid;

  logic [2:0]    s1_st = '0;
  logic          s1_emp = 1'b0, s1_rdy = 1'b0;
  logic [1:0]    s1_pol = 2'd0;
  logic          s1_vld;
  logic          s1_tid;

  int checks = 0;
  int fails  = 0;
  int rr_q [N];
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  csel_commit_sel #(.NUM_THR(N), .SEQ_W(SW)) u_csel_commit_sel (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .thr_state_i(st),
    .thr_empty_i(emp), .thr_ready_i(rdy), .thr_seq_i(seq), .advance_i(adv),
    .grant_vld_o(g_vld), .grant_tid_o(g_tid)
  );

  csel_commit_sel #(.NUM_THR(1), .SEQ_W(SW)) u_csel_commit_sel_single (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(s1_pol), .thr_state_i(s1_st),
    .thr_empty_i(s1_emp), .thr_ready_i(s1_rdy), .thr_seq_i(4'd0), .advance_i(1'b0),
    .grant_vld_o(s1_vld), .grant_tid_o(s1_tid)
  );

  function automatic bit elig(input logic [2:0] s);
    return (s == 3'd0) | (s == 3'd1) | (s == 3'd4);
  endfunction

  function automatic bit qualified(input int t);
    return elig(st[t*3 +: 3]) && !emp[t] && rdy[t];
  endfunction

  task automatic expect_grant(output bit ev, output int et);
    int key, best;
    ev = 0; et = 0; best = 1 << 30;
    if (pol == 2'd1) begin
      for (int p = 0; p < N; p++)
        if (!ev && qualified(rr_q[p])) begin ev = 1; et = rr_q[p]; end
    end else if (pol != 2'd3) begin
      for (int t = 0; t < N; t++) begin
        key = int'(seq[t*SW +: SW]) * 16 + t;   // age first, index breaks ties
        if (qualified(t) && key < best) begin best = key; ev = 1; et = t; end
      end
    end
  endtask

  task automatic cmp(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (pol %0d)", req, act, exp, pol);
    end
  endtask

  function automatic string tag(input bit ev);
    if (!ev) return "R2";
    case (pol)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R3";
      default: return "R9";
    endcase
  endfunction

  // drive at negedge, compare mid-phase, model list at the following posedge
  task automatic step_check();
    bit ev; int et;
    #5;
    expect_grant(ev, et);
    cmp(tag(ev), int'(g_vld), int'(ev));
    cmp(tag(ev), int'(g_tid), ev ? et : 0);
    if (adv && ev && pol == 2'd1) begin   // R7 list move; otherwise R8 hold
      int g;
      int k;
      g = et; k = 0;
      for (int p = 0; p < N; p++) if (rr_q[p] != g) begin rr_q[k] = rr_q[p]; k++; end
      rr_q[N-1] = g;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    for (int p = 0; p < N; p++) rr_q[p] = p;
    st = {N{3'd2}};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // reset state with nobody eligible: R2
    pol = 2'd1; step_check();

    // R6: all qualified, rotate picks front = 0; R7 sequence 0,1,2,3,0
    @(negedge clk); st = '0; emp = '0; rdy = '1; adv = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cmp("R6", int'(g_tid), i % N);
      step_check();
      @(negedge clk);
    end
    // R8: advance under age policy leaves the order untouched
    pol = 2'd2; step_check(); @(negedge clk);
    pol = 2'd1; adv = 1'b0; step_check();
    cmp("R8", int'(g_tid), 1);

    // R1: exhaustive state codes for one lone qualified thread
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      pol = 2'd2; adv = 1'b0;
      st = {N{3'd2}}; st[2*3 +: 3] = 3'(s); emp = '0; rdy = '1;
      step_check();
      cmp("R1", int'(g_vld), int'(elig(3'(s))));
    end

    // near-exhaustive sweep over all policies, ties frequent with 4-bit seq
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      pol = 2'(i % 4);
      st  = N*3'($urandom);
      for (int t = 0; t < N; t++) if ($urandom % 3 != 0) st[t*3 +: 3] = ($urandom % 2) ? 3'd1 : 3'd4;
      emp = N'($urandom) & N'($urandom);
      rdy = N'($urandom) | N'($urandom);
      seq = (N*SW)'($urandom);
      adv = 1'($urandom);
      step_check();
    end

    // R10: single-thread build ignores ready, empty and policy
    adv = 1'b0;
    for (int s = 0; s < 8; s++)
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        s1_st = 3'(s); s1_emp = b[0]; s1_rdy = b[1]; s1_pol = 2'(b >> 2);
        #5;
        checks++;
        if (s1_vld != elig(3'(s)) || s1_tid != 1'b0) begin
          fails++;
          $display("FAIL R10: actual %0d expected %0d", s1_vld, elig(3'(s)));
        end
      end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule